// File: doc/BRIEF.md
# Modem-Change and Two-Channel Interrupt Controller

This block holds the receive control/status register of a serial line controller and turns line and buffer events into prioritized interrupt requests for a bus processor. Four modem status lines (clear to send, carrier detect, data set ready, ring indicator) come in asynchronously. Each line passes a two-flop synchronizer and is compared with a registered copy of itself, so an edge in either direction on a line is seen as a change. A static per-line enable mask decides which lines may set the sticky data-set-change flag in bit 15. Reading the register clears the flag.

Interrupts use two channels. The receive channel is raised by receive status ready, receive data ready, or the data-set-change flag. The flag only counts when both the data-set interrupt enable and the receiver interrupt enable are set. The transmit channel is raised by transmit buffer empty when the transmit interrupt enable in the transmit control byte is set. A channel's request is armed on the rising edge of its qualified condition. It is then held until the channel is acknowledged or the condition goes away. On an acknowledge the block returns the vector of the winning channel. Receive always wins over transmit, and the transmit vector is the receive vector plus 4.

Top module: `modem_irq_ctrl`

## Requirements
- R1: A level change in either direction on an enabled modem line sets bit 15 (data-set change) of the receive register. The change becomes visible to a read started 4 clock cycles after the line moves.
- R2: A change on a modem line whose `mdm_en` bit is 0 leaves bit 15 at 0.
- R3: A read (`csr_rd`) returns the register value from before the read on `csr_rdata` one cycle later, and it clears bit 15. When a new change arrives in the same cycle as the read, the flag stays set.
- R4: Receive register layout: bit 15 is the change flag; bit 14 reads 0; bit 13 is receive data ready; bit 12 is receive status ready; bits 11:8 are the synchronized levels of modem lines 3..0; bits 7:0 are read/write, with bit 6 the receiver interrupt enable and bit 5 the data-set interrupt enable. `csr_be[0]` writes bits 7:0. Writes to bits 15:8 have no effect.
- R5: `irq_rx` rises when bit 6 is set and receive status ready or receive data ready is high.
- R6: The data-set-change flag raises `irq_rx` only when both bit 5 and bit 6 are set.
- R7: `irq_tx` rises when bit 6 of the transmit control byte (`txc_rdata`) is set and `tx_buf_empty` is high. The byte is read/write in all 8 bits.
- R8: A request stays set while its condition holds and no acknowledge serves it. It drops one cycle after its condition goes away. After being served, it is not raised again until the condition has fallen and risen once more.
- R9: On `irq_ack` with both requests pending, the next cycle gives `vec_valid`=1 and `vec_out`=RX_VEC, and only the receive request is cleared. A later acknowledge with only transmit pending gives RX_VEC+4.
- R10: After reset the register reads 0 with all modem lines low, the transmit byte is 0, and no request or vector is active. An acknowledge with nothing pending gives `vec_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Receive register write strobe |
| csr_be | input | 2 | Byte enables for the write (bit 0 low byte, bit 1 high byte) |
| csr_wdata | input | 16 | Write data |
| csr_rd | input | 1 | Receive register read strobe (clears the change flag) |
| csr_rdata | output | 16 | Registered read data, valid the cycle after `csr_rd` |
| txc_wr | input | 1 | Transmit control byte write strobe |
| txc_wdata | input | 8 | Transmit control byte write data |
| txc_rdata | output | 8 | Transmit control byte contents |
| mdm_in | input | 4 | Asynchronous modem status lines |
| mdm_en | input | 4 | Static per-line enable for change detection |
| rx_stat_rdy | input | 1 | Receive status ready |
| rx_data_rdy | input | 1 | Receive data ready |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| irq_rx | output | 1 | Receive channel request pending |
| irq_tx | output | 1 | Transmit channel request pending |
| irq_req | output | 1 | Any request pending |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| vec_out | output | VEC_W | Vector of the served channel |
| vec_valid | output | 1 | Vector valid, one cycle after an acknowledge that served a channel |

## Verification
The hardest case to reach is a modem change that arrives in the same clock edge as a register read. Both a set and a clear of the flag then compete. The bench gets there by first leaving the flag set. It then toggles a line and counts the synchronizer and edge-register stages, so that the read strobe lands on the edge where the detected change is registered. Two follow-up reads show that the flag survived the first read and then cleared. Priority is reached by arming both channels before a single acknowledge.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int MDM_LANES = 4;
  localparam int DSC_BIT   = 15;
  localparam int RXIE_BIT  = 6;
  localparam int DSIE_BIT  = 5;
  localparam int TXIE_BIT  = 6;
  localparam int CH_RX     = 0;
  localparam int CH_TX     = 1;
  localparam int NUM_CH    = 2;
endpackage

// File: rtl/modem_change_det.sv
module modem_change_det #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] line_en,
  output logic [N-1:0] line_lvl,
  output logic         any_change
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= line_in[g];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign hit[g]      = (s2 ^ prev) & line_en[g];
    assign line_lvl[g] = s2;
  end

  assign any_change = |hit;
endmodule

// File: rtl/rx_csr_regs.sv
module rx_csr_regs
  import mic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [1:0]           be,
  input  logic [15:0]          wdata,
  input  logic                 rd,
  input  logic                 change,
  input  logic [MDM_LANES-1:0] lvl,
  input  logic                 stat_rdy,
  input  logic                 data_rdy,
  output logic [15:0]          rdata,
  output logic                 rx_ie,
  output logic                 ds_ie,
  output logic                 dsc
);
  logic [7:0]  ctl_q;
  logic [15:0] view;

  always_comb begin
    view           = 16'h0000;
    view[7:0]      = ctl_q;
    view[11:8]     = lvl;
    view[12]       = stat_rdy;
    view[13]       = data_rdy;
    view[DSC_BIT]  = dsc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      dsc   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr && be[0]) ctl_q <= wdata[7:0];
      if (change)      dsc <= 1'b1;
      else if (rd)     dsc <= 1'b0;
      if (rd)          rdata <= view;
    end
  end

  assign rx_ie = ctl_q[RXIE_BIT];
  assign ds_ie = ctl_q[DSIE_BIT];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import mic_pkg::*;
#(
  parameter int               VEC_W  = 9,
  parameter logic [VEC_W-1:0] RX_VEC = 9'h0A0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cond,
  input  logic              ack,
  output logic [NUM_CH-1:0] pend,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid
);
  localparam logic [VEC_W-1:0] TX_VEC = VEC_W'(RX_VEC + 4);

  logic [NUM_CH-1:0] served;

  assign served[CH_RX] = ack & pend[CH_RX];
  assign served[CH_TX] = ack & pend[CH_TX] & ~pend[CH_RX];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cond_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cond_q  <= 1'b0;
        pend[c] <= 1'b0;
      end else begin
        cond_q  <= cond[c];
        pend[c] <= cond[c] & ~served[c] & (pend[c] | ~cond_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= |served;
      if (served[CH_RX])      vec_out <= RX_VEC;
      else if (served[CH_TX]) vec_out <= TX_VEC;
    end
  end
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
  import mic_pkg::*;
#(
  parameter int               VEC_W  = 9,
  parameter logic [VEC_W-1:0] RX_VEC = 9'h0A0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_wr,
  input  logic [1:0]       csr_be,
  input  logic [15:0]      csr_wdata,
  input  logic             csr_rd,
  output logic [15:0]      csr_rdata,
  input  logic             txc_wr,
  input  logic [7:0]       txc_wdata,
  output logic [7:0]       txc_rdata,
  input  logic [3:0]       mdm_in,
  input  logic [3:0]       mdm_en,
  input  logic             rx_stat_rdy,
  input  logic             rx_data_rdy,
  input  logic             tx_buf_empty,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_req,
  input  logic             irq_ack,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  logic [MDM_LANES-1:0] lvl;
  logic                 change;
  logic                 rx_ie, ds_ie, dsc, tx_ie;
  logic [7:0]           txc_q;
  logic [NUM_CH-1:0]    cond, pend;

  modem_change_det #(.N(MDM_LANES)) u_det (
    .clk(clk), .rst(rst), .line_in(mdm_in), .line_en(mdm_en),
    .line_lvl(lvl), .any_change(change)
  );

  rx_csr_regs u_regs (
    .clk(clk), .rst(rst), .wr(csr_wr), .be(csr_be), .wdata(csr_wdata),
    .rd(csr_rd), .change(change), .lvl(lvl), .stat_rdy(rx_stat_rdy),
    .data_rdy(rx_data_rdy), .rdata(csr_rdata), .rx_ie(rx_ie),
    .ds_ie(ds_ie), .dsc(dsc)
  );

  always_ff @(posedge clk) begin
    if (rst)         txc_q <= '0;
    else if (txc_wr) txc_q <= txc_wdata;
  end
  assign txc_rdata = txc_q;
  assign tx_ie     = txc_q[TXIE_BIT];

  assign cond[CH_RX] = rx_ie & (rx_stat_rdy | rx_data_rdy | (ds_ie & dsc));
  assign cond[CH_TX] = tx_ie & tx_buf_empty;

  irq_prio_arb #(.VEC_W(VEC_W), .RX_VEC(RX_VEC)) u_arb (
    .clk(clk), .rst(rst), .cond(cond), .ack(irq_ack), .pend(pend),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  assign irq_rx  = pend[CH_RX];
  assign irq_tx  = pend[CH_TX];
  assign irq_req = |pend;
endmodule

// File: rtl/mic_chk.sv
module mic_chk #(
  parameter int               VEC_W  = 9,
  parameter logic [VEC_W-1:0] RX_VEC = 9'h0A0
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_ack,
  input logic             irq_rx,
  input logic             irq_tx,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic             rx_ie,
  input logic             ds_ie,
  input logic             dsc,
  input logic             tx_ie,
  input logic             rx_stat_rdy,
  input logic             rx_data_rdy,
  input logic             tx_buf_empty
);
  // R5
  rx_cond_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(rx_ie && (rx_stat_rdy || rx_data_rdy || (ds_ie && dsc))));
  // R6
  dsc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_rx && !$past(rx_stat_rdy || rx_data_rdy)) |-> $past(rx_ie && ds_ie && dsc));
  // R7
  tx_cond_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(tx_ie && tx_buf_empty));
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_rx && !irq_ack && rx_ie && (rx_stat_rdy || rx_data_rdy || (ds_ie && dsc))) |=> irq_rx);
  // R9
  rx_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_rx) |=> (vec_valid && vec_out == RX_VEC && !irq_rx));
  // R9
  tx_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_rx && irq_tx) |=> (vec_valid && vec_out == VEC_W'(RX_VEC + 4)));
  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_ack || (!irq_rx && !irq_tx)) |=> !vec_valid);
endmodule

bind modem_irq_ctrl mic_chk #(.VEC_W(VEC_W), .RX_VEC(RX_VEC)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .vec_valid(vec_valid), .vec_out(vec_out), .rx_ie(rx_ie), .ds_ie(ds_ie),
  .dsc(dsc), .tx_ie(tx_ie), .rx_stat_rdy(rx_stat_rdy),
  .rx_data_rdy(rx_data_rdy), .tx_buf_empty(tx_buf_empty)
);

// File: tb/sim_modem_irq_ctrl.sv
module sim_modem_irq_ctrl;
  localparam int         VW  = 9;
  localparam logic [8:0] RXV = 9'h0A0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_wr = 0, csr_rd = 0, txc_wr = 0;
  logic [1:0] csr_be = 0;
  logic [15:0] csr_wdata = 0, csr_rdata;
  logic [7:0] txc_wdata = 0, txc_rdata;
  logic [3:0] mdm_in = 0, mdm_en = 0;
  logic rx_stat_rdy = 0, rx_data_rdy = 0, tx_buf_empty = 0, irq_ack = 0;
  logic irq_rx, irq_tx, irq_req, vec_valid;
  logic [VW-1:0] vec_out;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  modem_irq_ctrl #(.VEC_W(VW), .RX_VEC(RXV)) u0 (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_be(csr_be), .csr_wdata(csr_wdata),
    .csr_rd(csr_rd), .csr_rdata(csr_rdata), .txc_wr(txc_wr), .txc_wdata(txc_wdata),
    .txc_rdata(txc_rdata), .mdm_in(mdm_in), .mdm_en(mdm_en),
    .rx_stat_rdy(rx_stat_rdy), .rx_data_rdy(rx_data_rdy), .tx_buf_empty(tx_buf_empty),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_req(irq_req), .irq_ack(irq_ack),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_csr(output logic [15:0] v);
    @(negedge clk) csr_rd = 1;
    @(negedge clk) csr_rd = 0;
    v = csr_rdata;
  endtask

  task automatic wr_csr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk) begin csr_wr = 1; csr_be = be; csr_wdata = d; end
    @(negedge clk) csr_wr = 0;
  endtask

  task automatic wr_txc(input logic [7:0] d);
    @(negedge clk) begin txc_wr = 1; txc_wdata = d; end
    @(negedge clk) txc_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    @(negedge clk) rst = 0;
    // R10 reset state
    chk("R10 irq_req", irq_req, 0);
    chk("R10 vec_valid", vec_valid, 0);
    chk("R10 txc", txc_rdata, 0);
    rd_csr(v);
    chk("R10 csr", v, 0);
    ack();
    chk("R10 idle ack", vec_valid, 0);

    // R1 / R2 exhaustive mask x lane sweep
    for (int en = 0; en < 16; en++) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk) mdm_en = 4'(en);
        rd_csr(v);
        @(negedge clk) mdm_in[i] = ~mdm_in[i];
        cyc(4);
        rd_csr(v);
        if (en[i]) chk("R1 enabled change sets flag", v[15], 1);
        else       chk("R2 masked change ignored", v[15], 0);
        chk("R4 modem levels", v[11:8], mdm_in);
      end
    end

    // R3 read clears flag
    @(negedge clk) mdm_en = 4'hF;
    @(negedge clk) mdm_in[2] = ~mdm_in[2];
    cyc(4);
    rd_csr(v);
    chk("R3 first read sees flag", v[15], 1);
    rd_csr(v);
    chk("R3 flag cleared by read", v[15], 0);

    // R3 change coincident with clearing read
    @(negedge clk) mdm_in[1] = ~mdm_in[1];
    cyc(4);
    @(negedge clk) mdm_in[3] = ~mdm_in[3];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) csr_rd = 1;
    @(negedge clk) csr_rd = 0;
    chk("R3 coincident read data", csr_rdata[15], 1);
    rd_csr(v);
    chk("R3 change beats clear", v[15], 1);
    rd_csr(v);
    chk("R3 cleared afterwards", v[15], 0);

    // R4 byte access
    wr_csr(2'b11, 16'hFFFF);
    rd_csr(v);
    chk("R4 word write", v, {4'b0000, mdm_in, 8'hFF});
    wr_csr(2'b01, 16'h00A5);
    rd_csr(v);
    chk("R4 low byte write", v, {4'b0000, mdm_in, 8'hA5});
    wr_csr(2'b10, 16'hFF5A);
    rd_csr(v);
    chk("R4 high byte read-only", v, {4'b0000, mdm_in, 8'hA5});
    @(negedge clk) begin rx_stat_rdy = 1; rx_data_rdy = 0; end
    rd_csr(v);
    chk("R4 status ready bit 12", v[13:12], 2'b01);
    @(negedge clk) begin rx_stat_rdy = 0; rx_data_rdy = 1; end
    rd_csr(v);
    chk("R4 data ready bit 13", v[13:12], 2'b10);
    @(negedge clk) rx_data_rdy = 0;
    wr_csr(2'b01, 16'h0000);

    // R5 / R6 sweep over enables, sources and flag
    for (int k = 0; k < 32; k++) begin
      logic rie, die, st, dt, fl, exp_rx;
      rie = k[0]; die = k[1]; st = k[2]; dt = k[3]; fl = k[4];
      wr_csr(2'b01, 16'h0000);
      @(negedge clk) begin rx_stat_rdy = 0; rx_data_rdy = 0; end
      rd_csr(v);
      cyc(2);
      if (fl) begin
        @(negedge clk) mdm_in[0] = ~mdm_in[0];
        cyc(4);
      end
      @(negedge clk) begin rx_stat_rdy = st; rx_data_rdy = dt; end
      wr_csr(2'b01, {8'h00, 1'b0, rie, die, 5'b0});
      cyc(2);
      exp_rx = rie & (st | dt | (die & fl));
      if (!st && !dt) chk("R6 flag request gating", irq_rx, exp_rx);
      else            chk("R5 receive request", irq_rx, exp_rx);
      chk("R5 irq_req", irq_req, exp_rx);
    end
    wr_csr(2'b01, 16'h0000);
    @(negedge clk) begin rx_stat_rdy = 0; rx_data_rdy = 0; end
    rd_csr(v);
    cyc(2);

    // R7 transmit sweep
    for (int k = 0; k < 4; k++) begin
      wr_txc(8'h00);
      @(negedge clk) tx_buf_empty = 0;
      cyc(2);
      @(negedge clk) tx_buf_empty = k[1];
      wr_txc(k[0] ? 8'h40 : 8'hBF);
      cyc(2);
      chk("R7 transmit request", irq_tx, k[0] & k[1]);
      chk("R7 txc readback", txc_rdata, k[0] ? 8'h40 : 8'hBF);
    end

    // R8 drop when condition goes away
    @(negedge clk) rx_stat_rdy = 1;
    wr_csr(2'b01, 16'h0040);
    cyc(3);
    chk("R8 held", irq_rx, 1);
    @(negedge clk) rx_stat_rdy = 0;
    @(negedge clk);
    chk("R8 drop on condition loss", irq_rx, 0);

    // R9 priority with both pending (tx still armed from sweep)
    @(negedge clk) rx_data_rdy = 1;
    cyc(2);
    chk("R9 both pending rx", irq_rx, 1);
    chk("R9 both pending tx", irq_tx, 1);
    ack();
    chk("R9 vec valid rx", vec_valid, 1);
    chk("R9 rx vector", vec_out, RXV);
    chk("R9 rx cleared", irq_rx, 0);
    chk("R9 tx kept", irq_tx, 1);
    cyc(2);
    chk("R8 not re-raised after serve", irq_rx, 0);
    ack();
    chk("R9 vec valid tx", vec_valid, 1);
    chk("R9 tx vector", vec_out, RXV + 9'd4);
    chk("R9 tx cleared", irq_tx, 0);
    @(negedge clk) rx_data_rdy = 0;
    cyc(2);
    @(negedge clk) rx_data_rdy = 1;
    cyc(2);
    chk("R8 re-armed after fall and rise", irq_rx, 1);
    ack();
    chk("R10 rearm vector", vec_out, RXV);
    ack();
    chk("R10 idle ack no vector", vec_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule